// File: doc/BRIEF.md
# Sized-Write Word Memory Slave with Abort Window

This block is a synchronous memory slave for a 32-bit processor bus. Storage is organised as whole words. A request is taken on a clock edge while the active-low request strobe is low. A read always returns the full aligned word, and the processor extracts any byte or halfword it wants. A byte or halfword write is merged into the stored word in a single cycle. A static endianness input decides which lane the merged data lands in.

An address window, set by parameters, refuses accesses. Any request whose address falls inside it is not performed. Instead the slave returns a fixed abort word and raises one of two flags. A prefetch abort is raised when the request is an opcode fetch, and a data abort otherwise.

A small response state machine holds the outcome of the last request. It has four states:
- `ST_IDLE`: no request has been taken since reset.
- `ST_DONE`: the last request completed.
- `ST_PABT`: the last request was a fetch that aborted.
- `ST_DABT`: the last request was a data access that aborted.

Every taken request moves the machine into one of `ST_DONE`, `ST_PABT` or `ST_DABT`. Cycles without a request keep the current state.

Top module: `sized_mem_slave`

## Requirements
- R1: After reset, `rdata`, `pabort` and `dabort` are 0, and every stored word reads back as 0.
- R2: While `mreq_n` is high, storage does not change and `rdata`, `pabort` and `dabort` keep their values.
- R3: A read request (`mreq_n`=0, `wr`=0) outside the window gives, one cycle later, the whole stored word at word index `addr[IW+1:2]` on `rdata`, whatever the value of `size`.
- R4: A write with `size`=2'b10 (word) replaces all 32 bits with `wdata`, and `addr[1:0]` have no effect.
- R5: A write with `size`=2'b00 (byte) replaces only the 8-bit lane at bit offset 8*(({big_endian,big_endian}) XOR `addr[1:0]`) with `wdata[7:0]`.
- R6: A write with `size`=2'b01 (halfword) replaces only the 16-bit lane at bit offset 16*(`big_endian` XOR `addr[1]`) with `wdata[15:0]`, and `addr[0]` has no effect.
- R7: A write with `size`=2'b11 (reserved) changes no storage.
- R8: A request with ABORT_LO <= `addr` < ABORT_HI writes nothing and gives `rdata` = ABORT_WORD one cycle later.
- R9: An aborted request raises `pabort` (and not `dabort`) when `fetch_n` is 0. It raises `dabort` (and not `pabort`) when `fetch_n` is 1.
- R10: A request outside the window clears both abort flags one cycle later.
- R11: Address bits above the word index select no different storage outside the window, so aliased addresses reach the same word.
- R12: A write request outside the window gives `rdata` = 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mreq_n | input | 1 | Active-low request strobe |
| wr | input | 1 | 1 = write, 0 = read |
| fetch_n | input | 1 | 0 = opcode fetch, 1 = data access |
| size | input | 2 | Transfer size: 00 byte, 01 halfword, 10 word, 11 reserved |
| big_endian | input | 1 | Static lane ordering select |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data, right-aligned for sub-word sizes |
| rdata | output | 32 | Registered read data or abort word |
| pabort | output | 1 | Last request was an aborted fetch |
| dabort | output | 1 | Last request was an aborted data access |

## Verification
The bench builds the slave with DEPTH=16 and moves the abort window down to byte addresses 0x100 through 0x1FF. With these values, random addresses land often in the window, on both of its edges, in the array proper, and in aliased regions well above it. A reference word array in the bench tracks every merge, so both endian settings, all lanes and the reserved size are compared on read-back.

// File: rtl/wmem_pkg.sv
package wmem_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DONE = 2'd1,
        ST_PABT = 2'd2,
        ST_DABT = 2'd3
    } resp_state_e;
endpackage

// File: rtl/wmem_window.sv
module wmem_window #(
    parameter logic [31:0] ABORT_LO = 32'h0080_0000,
    parameter logic [31:0] ABORT_HI = 32'h01A0_0000
) (
    input  logic [31:0] addr,
    output logic        hit
);
    always_comb begin
        hit = (addr >= ABORT_LO) && (addr < ABORT_HI);
    end
endmodule

// File: rtl/wmem_merge.sv
module wmem_merge
    import wmem_pkg::*;
#(
    parameter int DW = 32,
    localparam int NLANE = DW / 8
) (
    input  logic [DW-1:0] old_word,
    input  logic [DW-1:0] wdata,
    input  xfer_size_e    size,
    input  logic [1:0]    lane_addr,
    input  logic          big_endian,
    output logic [DW-1:0] new_word,
    output logic          any_lane
);
    logic [NLANE-1:0] lane_en;
    logic [DW-1:0]    placed;
    logic [1:0]       byte_lane;
    logic             half_hi;

    always_comb begin
        byte_lane = {big_endian, big_endian} ^ lane_addr;
        half_hi   = big_endian ^ lane_addr[1];
        lane_en   = '0;
        placed    = wdata;
        unique case (size)
            SZ_BYTE: begin
                lane_en[byte_lane] = 1'b1;
                placed = {NLANE{wdata[7:0]}};
            end
            SZ_HALF: begin
                lane_en = half_hi ? 4'b1100 : 4'b0011;
                placed  = {2{wdata[15:0]}};
            end
            SZ_WORD: lane_en = '1;
            SZ_RSVD: lane_en = '0;
        endcase
        any_lane = |lane_en;
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign new_word[g*8 +: 8] = lane_en[g] ? placed[g*8 +: 8] : old_word[g*8 +: 8];
    end
endmodule

// File: rtl/wmem_store.sv
module wmem_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] idx,
    input  logic [DW-1:0] wword,
    output logic [DW-1:0] rword
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[idx] <= wword;
        end
    end

    assign rword = cells[idx];
endmodule

// File: rtl/sized_mem_slave.sv
module sized_mem_slave
    import wmem_pkg::*;
#(
    parameter int          DEPTH      = 64,
    parameter logic [31:0] ABORT_LO   = 32'h0080_0000,
    parameter logic [31:0] ABORT_HI   = 32'h01A0_0000,
    parameter logic [31:0] ABORT_WORD = 32'hBADA_B047,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mreq_n,
    input  logic        wr,
    input  logic        fetch_n,
    input  logic [1:0]  size,
    input  logic        big_endian,
    input  logic [31:0] addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        pabort,
    output logic        dabort
);
    resp_state_e   state_q, state_d;
    logic          win_hit;
    logic          any_lane;
    logic          store_we;
    logic [IW-1:0] word_idx;
    logic [31:0]   cur_word, merged_word;

    assign word_idx = addr[IW+1:2];

    wmem_window #(.ABORT_LO(ABORT_LO), .ABORT_HI(ABORT_HI)) u_window (
        .addr (addr),
        .hit  (win_hit)
    );

    wmem_merge #(.DW(32)) u_merge (
        .old_word   (cur_word),
        .wdata      (wdata),
        .size       (xfer_size_e'(size)),
        .lane_addr  (addr[1:0]),
        .big_endian (big_endian),
        .new_word   (merged_word),
        .any_lane   (any_lane)
    );

    assign store_we = !mreq_n && wr && !win_hit && any_lane;

    wmem_store #(.DEPTH(DEPTH), .DW(32)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .idx   (word_idx),
        .wword (merged_word),
        .rword (cur_word)
    );

    always_comb begin
        state_d = state_q;
        if (!mreq_n) begin
            if (win_hit) state_d = fetch_n ? ST_DABT : ST_PABT;
            else         state_d = ST_DONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata   <= '0;
        end else begin
            state_q <= state_d;
            if (!mreq_n) begin
                if (win_hit) rdata <= ABORT_WORD;
                else if (wr) rdata <= '0;
                else         rdata <= cur_word;
            end
        end
    end

    always_comb begin
        pabort = 1'b0;
        dabort = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DONE: ;
            ST_PABT: pabort = 1'b1;
            ST_DABT: dabort = 1'b1;
        endcase
    end
endmodule

// File: rtl/wmem_checker.sv
module wmem_checker #(
    parameter logic [31:0] ABORT_LO   = 32'h0080_0000,
    parameter logic [31:0] ABORT_HI   = 32'h01A0_0000,
    parameter logic [31:0] ABORT_WORD = 32'hBADA_B047
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mreq_n,
    input logic        wr,
    input logic        fetch_n,
    input logic [31:0] addr,
    input logic [31:0] rdata,
    input logic        pabort,
    input logic        dabort
);
    logic in_win;
    assign in_win = (addr >= ABORT_LO) && (addr < ABORT_HI);

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_n |=> ($stable(rdata) && $stable(pabort) && $stable(dabort)));

    assert_abort_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && in_win) |=> (rdata == ABORT_WORD));

    assert_fetch_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && in_win && !fetch_n) |=> (pabort && !dabort));

    assert_data_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && in_win && fetch_n) |=> (dabort && !pabort));

    assert_flags_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && !in_win) |=> (!pabort && !dabort));

    assert_write_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!mreq_n && !in_win && wr) |=> (rdata == 32'h0));
endmodule

bind sized_mem_slave wmem_checker #(
    .ABORT_LO   (ABORT_LO),
    .ABORT_HI   (ABORT_HI),
    .ABORT_WORD (ABORT_WORD)
) u_wmem_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .mreq_n  (mreq_n),
    .wr      (wr),
    .fetch_n (fetch_n),
    .addr    (addr),
    .rdata   (rdata),
    .pabort  (pabort),
    .dabort  (dabort)
);

// File: tb/tb_sized_mem_slave.sv
module tb_sized_mem_slave;
    localparam int          DEPTH = 16;
    localparam logic [31:0] LO    = 32'h0000_0100;
    localparam logic [31:0] HI    = 32'h0000_0200;
    localparam logic [31:0] ABW   = 32'hBADA_B047;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mreq_n = 1'b1;
    logic        wr = 1'b0;
    logic        fetch_n = 1'b1;
    logic [1:0]  size = 2'b10;
    logic        big_endian = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pabort, dabort;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] model [DEPTH];

    always #5 clk = ~clk;

    sized_mem_slave #(
        .DEPTH(DEPTH), .ABORT_LO(LO), .ABORT_HI(HI), .ABORT_WORD(ABW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .wr(wr), .fetch_n(fetch_n),
        .size(size), .big_endian(big_endian), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pabort(pabort), .dabort(dabort)
    );

    function automatic logic [31:0] merge_exp(logic [31:0] old, logic [31:0] wd,
                                              logic [1:0] sz, logic [1:0] a, logic big);
        int sh;
        logic [31:0] mask;
        case (sz)
            2'b10: return wd;
            2'b00: begin
                sh = 8 * int'({big, big} ^ a);
                mask = 32'hFF << sh;
                return (old & ~mask) | ((wd & 32'hFF) << sh);
            end
            2'b01: begin
                sh = 16 * int'(big ^ a[1]);
                mask = 32'hFFFF << sh;
                return (old & ~mask) | ((wd & 32'hFFFF) << sh);
            end
            default: return old;
        endcase
    endfunction

    function automatic int idx_of(logic [31:0] a);
        return int'(a[5:2]);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(logic [31:0] a, logic [31:0] wd, logic [1:0] sz,
                          logic w, logic fn, string tag);
        logic [31:0] exp_r;
        logic        exp_p, exp_d, hit;
        @(negedge clk);
        addr = a; wdata = wd; size = sz; wr = w; fetch_n = fn; mreq_n = 1'b0;
        hit = (a >= LO) && (a < HI);
        if (hit) begin
            exp_r = ABW; exp_p = !fn; exp_d = fn;
        end else begin
            exp_p = 1'b0; exp_d = 1'b0;
            if (w) begin
                exp_r = 32'h0;
                model[idx_of(a)] = merge_exp(model[idx_of(a)], wd, sz, a[1:0], big_endian);
            end else begin
                exp_r = model[idx_of(a)];
            end
        end
        @(negedge clk);
        mreq_n = 1'b1;
        check({tag, " rdata"}, rdata, exp_r);
        check({tag, " pabort"}, {31'b0, pabort}, {31'b0, exp_p});
        check({tag, " dabort"}, {31'b0, dabort}, {31'b0, exp_d});
    endtask

    task automatic readback(logic [31:0] a, string tag);
        access(a, 32'h0, $urandom % 4, 1'b0, 1'b1, tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r0;
        logic        p0, d0;
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 rdata", rdata, 32'h0);
        check("R1 flags", {30'b0, pabort, dabort}, 32'h0);
        rst_n = 1'b1;
        readback(32'h0000_0014, "R1 cleared word");

        // R4: word write, low addr bits ignored
        access(32'h0000_0007, 32'h1122_3344, 2'b10, 1'b1, 1'b1, "R4 R12 word write");
        readback(32'h0000_0004, "R4 R3 word readback");

        // R5: byte lanes, both endian settings
        for (int be = 0; be < 2; be++) begin
            big_endian = 1'(be);
            for (int ln = 0; ln < 4; ln++) begin
                access(32'h0000_0020 | ln, 32'hFFFF_FF00 | (ln + 16 * be + 1),
                       2'b00, 1'b1, 1'b1, "R5 byte write");
                readback(32'h0000_0020, "R5 byte readback");
            end
        end
        // R6: halfword lanes, addr[0] set
        for (int be = 0; be < 2; be++) begin
            big_endian = 1'(be);
            access(32'h0000_0031, 32'hAAAA_1234 + be, 2'b01, 1'b1, 1'b1, "R6 half low");
            access(32'h0000_0033, 32'hBBBB_5678 + be, 2'b01, 1'b1, 1'b1, "R6 half high");
            readback(32'h0000_0030, "R6 half readback");
        end
        big_endian = 1'b0;
        // R7: reserved size writes nothing
        access(32'h0000_0030, 32'hDEAD_BEEF, 2'b11, 1'b1, 1'b1, "R7 reserved write");
        readback(32'h0000_0030, "R7 unchanged");
        // R11: aliasing above the index
        access(32'h0000_2008, 32'hCAFE_F00D, 2'b10, 1'b1, 1'b1, "R11 alias write");
        readback(32'h0000_0008, "R11 alias readback");
        // R8 R9: window edges and flag types
        access(LO, 32'h5555_5555, 2'b10, 1'b1, 1'b0, "R8 R9 fetch abort at low edge");
        access(HI - 1, 32'h6666_6666, 2'b10, 1'b1, 1'b1, "R8 R9 data abort at high edge");
        // R2: idle keeps outputs and storage
        @(negedge clk);
        r0 = rdata; p0 = pabort; d0 = dabort;
        addr = 32'h0000_0008; wdata = 32'h0; wr = 1'b1; size = 2'b10; mreq_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R2 rdata held", rdata, r0);
        check("R2 flags held", {30'b0, pabort, dabort}, {30'b0, p0, d0});
        readback(32'h0000_0008, "R2 storage unchanged");
        // R10: next non-window request clears flags
        access(HI, 32'h0, 2'b10, 1'b0, 1'b1, "R10 R3 clear after abort at HI");
        access(LO - 1, 32'h0, 2'b00, 1'b0, 1'b0, "R10 R3 read below LO");

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            int kind;
            string tg;
            kind = $urandom % 4;
            case (kind)
                0: a = $urandom & 32'h3F;
                1: a = (32'h1000 * (1 + $urandom % 8)) | ($urandom & 32'h3F);
                2: a = LO + ($urandom % 256);
                default: begin
                    case ($urandom % 4)
                        0: a = LO - 1;
                        1: a = LO;
                        2: a = HI - 1;
                        default: a = HI;
                    endcase
                end
            endcase
            if ($urandom % 8 == 0) big_endian = ~big_endian;
            if ((a >= LO) && (a < HI)) tg = "R8 R9 random abort";
            else if (kind == 1) tg = "R11 R3 R5 R6 random alias";
            else tg = "R3 R4 R5 R6 R7 R10 random";
            access(a, $urandom, 2'($urandom), 1'($urandom), 1'($urandom), tg);
        end
        for (int i = 0; i < DEPTH; i++) readback(32'(i * 4), "R3 final sweep");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule